// File: doc/BRIEF.md
# Quadrature Encoder Simulator

This block produces the two-phase quadrature signals and the once-per-revolution index of an incremental shaft encoder. The angle-tracking logic can then run on a bench with no shaft turning. The simulated device has 1440 cycles per revolution, which gives 5760 quadrature states per turn. A 24-bit phase accumulator with a programmable increment sets the shaft speed. The motion can also be driven one quadrature state at a time. A signed slip offset can be added to the position to test slip detection further downstream.

The tracker-facing outputs carry one of two sources: the synthesized signals or the live encoder pins. A simulate/run request selects the source. The change is applied only at a revolution boundary, so the tracker never sees a partial or glitched transition between the two sources. In simulate mode the tracker receives the same signals that leave on the simulator's own output pins.

Top module: `qenc_sim`

## Requirements
- R1: After reset the synthesized outputs are A=0, B=0, Z=1 (position zero), the active mode is run (mode_sim=0), and the phase accumulator is zero.
- R2: The position counts modulo 5760. The synthesized pair {A,B} follows the position modulo 4 with 0→00, 1→01, 2→11, 3→10. Moving forward (dir_rev=0) increments the position and moving in reverse decrements it, so exactly one of A or B changes on each single-state move, including across the wrap.
- R3: Z is high exactly while the position is zero, with A=B=0 at that point, so it lasts one state per revolution.
- R4: While run_en=1, the 24-bit accumulator adds rate_inc on every clock, modulo 2^24. Each carry out moves the position by one state in the selected direction, and the outputs change on the same clock edge. An increment of 115965 at a 50 MHz clock gives just over 3600 RPM.
- R5: While run_en=0, a clock with step_req=1 moves the position by exactly one state in the selected direction. While run_en=1, step_req has no effect.
- R6: A clock with slip_req=1 adds slip_amt to the position, read as an 8-bit two's complement value, modulo 5760. It is added on top of any step or carry in the same clock.
- R7: The active mode takes the value of sim_sel (1 = simulate) only on a clock edge where the updated position is zero. At all other times it holds.
- R8: In simulate mode trk_a/trk_b/trk_z equal sim_a/sim_b/sim_z. In run mode they equal enc_a_in/enc_b_in/enc_z_in, without any added delay.
- R9: A clock with run_en=0, step_req=0 and slip_req=0 leaves the synthesized outputs unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| run_en | input | 1 | Free-running motion enable |
| rate_inc | input | 24 | Phase accumulator increment per clock |
| dir_rev | input | 1 | Direction: 0 forward, 1 reverse |
| step_req | input | 1 | Move one state (only while run_en=0) |
| slip_req | input | 1 | Apply slip offset this clock |
| slip_amt | input | 8 | Signed slip offset in states |
| sim_sel | input | 1 | Requested source: 1 simulate, 0 run |
| enc_a_in | input | 1 | Live encoder phase A |
| enc_b_in | input | 1 | Live encoder phase B |
| enc_z_in | input | 1 | Live encoder index |
| sim_a | output | 1 | Synthesized phase A |
| sim_b | output | 1 | Synthesized phase B |
| sim_z | output | 1 | Synthesized index |
| mode_sim | output | 1 | Active source: 1 simulate, 0 run |
| trk_a | output | 1 | Phase A toward the angle tracker |
| trk_b | output | 1 | Phase B toward the angle tracker |
| trk_z | output | 1 | Index toward the angle tracker |

## Verification
The single-change property on A and B assumes that no slip was applied in the previous clock, because a slip may legally jump several states. The property is therefore stated only for clocks without a slip. Random stimulus keeps slips rare and mixes slip-free stepping and running between them. The step property assumes that run_en is low and that no slip coincides with the step, and the stimulus exercises that combination directly. Mode changes are checked against the index. The stimulus drives the position to zero on purpose, both by slipping onto it and by running a full revolution, so that the switch point is reached in both directions.

// File: rtl/qenc_pkg.sv
// Package: shared types and helpers for the quadrature encoder simulator.
// Assumes the quadrature state count per revolution is a multiple of four.
package qenc_pkg;

    // Active source feeding the angle tracker.
    typedef enum logic {
        SRC_LIVE = 1'b0,
        SRC_SYNTH = 1'b1
    } src_mode_t;

    // Map the two low position bits onto the Gray-ordered {A,B} pair.
    function automatic logic [1:0] phase_pair(input logic [1:0] sub);
        logic [1:0] ab;
        case (sub)
            2'd0:    ab = 2'b00;
            2'd1:    ab = 2'b01;
            2'd2:    ab = 2'b11;
            default: ab = 2'b10;
        endcase
        return ab;
    endfunction

endpackage

// File: rtl/qenc_rate_gen.sv
// Module: qenc_rate_gen
// Phase accumulator that sets the simulated shaft speed. Each carry out of
// the accumulator requests one quadrature state of motion.
// Assumes rate_inc may change on any clock; the accumulator holds while idle.
module qenc_rate_gen #(
    parameter int ACC_W = 24
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run_en,
    input  logic [ACC_W-1:0] rate_inc,
    output logic             tick
);

    logic [ACC_W-1:0] acc_q;
    logic [ACC_W:0]   acc_sum;

    // Next accumulator value with carry in the top bit.
    always_comb begin
        acc_sum = {1'b0, acc_q} + {1'b0, rate_inc};
        tick    = run_en & acc_sum[ACC_W];
    end

    // Advance the accumulator only while free running.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_q <= '0;
        end else if (run_en) begin
            acc_q <= acc_sum[ACC_W-1:0];
        end
    end

endmodule

// File: rtl/qenc_position.sv
// Module: qenc_position
// Holds the simulated shaft position (modulo STATES quadrature states) and
// produces the registered A/B/Z outputs from the updated position.
// Assumes SLIP_W < POS_W so one step plus one slip never exceeds a revolution.
module qenc_position
    import qenc_pkg::*;
#(
    parameter int STATES = 5760,
    parameter int POS_W  = 13,
    parameter int SLIP_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              run_en,
    input  logic              step_req,
    input  logic              dir_rev,
    input  logic              slip_req,
    input  logic [SLIP_W-1:0] slip_amt,
    output logic              at_origin,
    output logic              sim_a,
    output logic              sim_b,
    output logic              sim_z
);

    localparam int SUM_W = POS_W + 2;
    localparam logic [SUM_W-1:0] STATES_W = SUM_W'(STATES);

    logic [POS_W-1:0] pos_q;
    logic [POS_W-1:0] pos_next;
    logic             move;
    logic [SUM_W-1:0] move_d;
    logic [SUM_W-1:0] slip_d;
    logic [SUM_W-1:0] raw_sum;
    logic [SUM_W-1:0] wrapped;
    logic [1:0]       ab_next;

    // Decide whether the shaft moves one state this clock.
    always_comb begin
        move = tick | (~run_en & step_req);
    end

    // Signed motion and slip deltas in two's complement, sign extended.
    always_comb begin
        move_d = '0;
        if (move) begin
            move_d = dir_rev ? {SUM_W{1'b1}} : SUM_W'(1);
        end
        slip_d = '0;
        if (slip_req) begin
            slip_d = {{(SUM_W - SLIP_W){slip_amt[SLIP_W-1]}}, slip_amt};
        end
    end

    // Add the deltas and fold the result back into one revolution.
    always_comb begin
        raw_sum = {2'b00, pos_q} + move_d + slip_d;
        if (raw_sum[SUM_W-1]) begin
            wrapped = raw_sum + STATES_W;
        end else if (raw_sum >= STATES_W) begin
            wrapped = raw_sum - STATES_W;
        end else begin
            wrapped = raw_sum;
        end
        pos_next  = wrapped[POS_W-1:0];
        at_origin = (pos_next == '0);
        ab_next   = phase_pair(pos_next[1:0]);
    end

    // Register position and outputs together so they change on one edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pos_q <= '0;
            sim_a <= 1'b0;
            sim_b <= 1'b0;
            sim_z <= 1'b1;
        end else begin
            pos_q <= pos_next;
            sim_a <= ab_next[1];
            sim_b <= ab_next[0];
            sim_z <= at_origin;
        end
    end

endmodule

// File: rtl/qenc_mode_sel.sv
// Module: qenc_mode_sel
// Chooses which encoder source feeds the angle tracker. A change of the
// requested source is applied only when the simulated position reaches zero.
// Assumes at_origin is the combinational "updated position is zero" flag.
module qenc_mode_sel
    import qenc_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic sim_sel,
    input  logic at_origin,
    input  logic sim_a,
    input  logic sim_b,
    input  logic sim_z,
    input  logic enc_a_in,
    input  logic enc_b_in,
    input  logic enc_z_in,
    output logic mode_sim,
    output logic trk_a,
    output logic trk_b,
    output logic trk_z
);

    src_mode_t mode_q;

    // Latch the requested source at the revolution boundary only.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q <= SRC_LIVE;
        end else if (at_origin) begin
            mode_q <= sim_sel ? SRC_SYNTH : SRC_LIVE;
        end
    end

    // Route the active source to the tracker without added delay.
    always_comb begin
        mode_sim = (mode_q == SRC_SYNTH);
        if (mode_q == SRC_SYNTH) begin
            trk_a = sim_a;
            trk_b = sim_b;
            trk_z = sim_z;
        end else begin
            trk_a = enc_a_in;
            trk_b = enc_b_in;
            trk_z = enc_z_in;
        end
    end

endmodule

// File: rtl/qenc_sim.sv
// Module: qenc_sim
// Quadrature encoder simulator top: speed generator, position keeper and
// source selector. Quadrature states per revolution are four times CYC_PER_REV.
// Assumes SLIP_W is smaller than the position width.
module qenc_sim #(
    parameter int ACC_W       = 24,
    parameter int CYC_PER_REV = 1440,
    parameter int SLIP_W      = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run_en,
    input  logic [ACC_W-1:0]  rate_inc,
    input  logic              dir_rev,
    input  logic              step_req,
    input  logic              slip_req,
    input  logic [SLIP_W-1:0] slip_amt,
    input  logic              sim_sel,
    input  logic              enc_a_in,
    input  logic              enc_b_in,
    input  logic              enc_z_in,
    output logic              sim_a,
    output logic              sim_b,
    output logic              sim_z,
    output logic              mode_sim,
    output logic              trk_a,
    output logic              trk_b,
    output logic              trk_z
);

    localparam int STATES = 4 * CYC_PER_REV;
    localparam int POS_W  = $clog2(STATES);

    logic tick;
    logic at_origin;

    qenc_rate_gen #(
        .ACC_W (ACC_W)
    ) i_rate (
        .clk      (clk),
        .rst_n    (rst_n),
        .run_en   (run_en),
        .rate_inc (rate_inc),
        .tick     (tick)
    );

    qenc_position #(
        .STATES (STATES),
        .POS_W  (POS_W),
        .SLIP_W (SLIP_W)
    ) i_pos (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (tick),
        .run_en    (run_en),
        .step_req  (step_req),
        .dir_rev   (dir_rev),
        .slip_req  (slip_req),
        .slip_amt  (slip_amt),
        .at_origin (at_origin),
        .sim_a     (sim_a),
        .sim_b     (sim_b),
        .sim_z     (sim_z)
    );

    qenc_mode_sel i_mode (
        .clk       (clk),
        .rst_n     (rst_n),
        .sim_sel   (sim_sel),
        .at_origin (at_origin),
        .sim_a     (sim_a),
        .sim_b     (sim_b),
        .sim_z     (sim_z),
        .enc_a_in  (enc_a_in),
        .enc_b_in  (enc_b_in),
        .enc_z_in  (enc_z_in),
        .mode_sim  (mode_sim),
        .trk_a     (trk_a),
        .trk_b     (trk_b),
        .trk_z     (trk_z)
    );

endmodule

// File: rtl/qenc_sim_chk.sv
// Module: qenc_sim_chk
// Protocol checker for qenc_sim, attached through bind. Observes ports only.
module qenc_sim_chk (
    input logic clk,
    input logic rst_n,
    input logic run_en,
    input logic step_req,
    input logic slip_req,
    input logic sim_a,
    input logic sim_b,
    input logic sim_z,
    input logic mode_sim
);

    // R2: without a slip, at most one phase changes per clock.
    a_r2_single_change: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(slip_req) |-> ($countones({sim_a, sim_b} ^ $past({sim_a, sim_b})) <= 1));

    // R3: the index is only ever high with both phases low.
    a_r3_index_phase: assert property (@(posedge clk) disable iff (!rst_n)
        sim_z |-> (!sim_a && !sim_b));

    // R5: a lone step while idle changes exactly one phase.
    a_r5_step_one: assert property (@(posedge clk) disable iff (!rst_n)
        (!run_en && step_req && !slip_req) |=>
            ($countones({sim_a, sim_b} ^ $past({sim_a, sim_b})) == 1));

    // R7: the active source changes only on an index state.
    a_r7_switch_at_index: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_sim != $past(mode_sim)) |-> sim_z);

    // R9: no motion request leaves the outputs untouched.
    a_r9_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (!run_en && !step_req && !slip_req) |=> $stable({sim_a, sim_b, sim_z}));

endmodule

bind qenc_sim qenc_sim_chk i_qenc_sim_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .run_en   (run_en),
    .step_req (step_req),
    .slip_req (slip_req),
    .sim_a    (sim_a),
    .sim_b    (sim_b),
    .sim_z    (sim_z),
    .mode_sim (mode_sim)
);

// File: tb/test_qenc_sim.sv
// Bench: behavioural reference model of the encoder simulator, compared on
// every clock at the falling edge. Inputs change at the falling edge too.
module test_qenc_sim;

    localparam int NSTATES = 5760;
    localparam longint ACC_MOD = 64'd16777216;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        run_en = 1'b0;
    logic [23:0] rate_inc = '0;
    logic        dir_rev = 1'b0;
    logic        step_req = 1'b0;
    logic        slip_req = 1'b0;
    logic [7:0]  slip_amt = '0;
    logic        sim_sel = 1'b0;
    logic        enc_a_in = 1'b0;
    logic        enc_b_in = 1'b0;
    logic        enc_z_in = 1'b0;
    logic        sim_a, sim_b, sim_z, mode_sim, trk_a, trk_b, trk_z;

    int     n_chk = 0;
    int     n_fail = 0;
    bit     done = 1'b0;
    longint acc_m = 0;
    int     pos_m = 0;
    bit     mode_m = 1'b0;

    always #10 clk = ~clk;

    qenc_sim i_qenc_sim (
        .clk(clk), .rst_n(rst_n), .run_en(run_en), .rate_inc(rate_inc),
        .dir_rev(dir_rev), .step_req(step_req), .slip_req(slip_req),
        .slip_amt(slip_amt), .sim_sel(sim_sel), .enc_a_in(enc_a_in),
        .enc_b_in(enc_b_in), .enc_z_in(enc_z_in), .sim_a(sim_a),
        .sim_b(sim_b), .sim_z(sim_z), .mode_sim(mode_sim),
        .trk_a(trk_a), .trk_b(trk_b), .trk_z(trk_z)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    // Compare all outputs against the model's post-edge state.
    task automatic compare_all();
        int  sub;
        bit  ea, eb, ez;
        sub = pos_m % 4;
        ea  = (sub == 2) || (sub == 3);
        eb  = (sub == 1) || (sub == 2);
        ez  = (pos_m == 0);
        check({sim_a, sim_b} == {ea, eb}, "R2/R4/R5/R6 phase pair",
              int'({sim_a, sim_b}), int'({ea, eb}));
        check(sim_z == ez, "R3 index", int'(sim_z), int'(ez));
        check(mode_sim == mode_m, "R7 mode", int'(mode_sim), int'(mode_m));
        if (mode_m)
            check({trk_a, trk_b, trk_z} == {ea, eb, ez}, "R8 tracker sim",
                  int'({trk_a, trk_b, trk_z}), int'({ea, eb, ez}));
        else
            check({trk_a, trk_b, trk_z} == {enc_a_in, enc_b_in, enc_z_in}, "R8 tracker live",
                  int'({trk_a, trk_b, trk_z}), int'({enc_a_in, enc_b_in, enc_z_in}));
    endtask

    // Apply one clock of stimulus, advance the model, then compare.
    task automatic cyc(input bit r, input bit d, input bit st, input bit sl,
                       input int amt, input bit ss);
        int delta;
        bit move;
        run_en   = r;
        dir_rev  = d;
        step_req = st;
        slip_req = sl;
        slip_amt = 8'(amt);
        sim_sel  = ss;
        move = 1'b0;
        if (r) begin
            acc_m = acc_m + longint'(rate_inc);
            if (acc_m >= ACC_MOD) begin
                acc_m = acc_m - ACC_MOD;
                move  = 1'b1;
            end
        end else if (st) begin
            move = 1'b1;
        end
        delta = move ? (d ? -1 : 1) : 0;
        if (sl) delta = delta + int'($signed(8'(amt)));
        pos_m = (pos_m + delta) % NSTATES;
        if (pos_m < 0) pos_m = pos_m + NSTATES;
        if (pos_m == 0) mode_m = ss;
        @(negedge clk);
        compare_all();
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: state right after reset release, before any active edge.
        check({sim_a, sim_b, sim_z} == 3'b001, "R1 reset outputs",
              int'({sim_a, sim_b, sim_z}), 1);
        check(mode_sim == 1'b0, "R1 reset mode", int'(mode_sim), 0);

        // R5, R2: forward steps, then reverse across the wrap.
        for (int i = 0; i < 8; i++) cyc(0, 0, 1, 0, 0, 0);
        for (int i = 0; i < 12; i++) cyc(0, 1, 1, 0, 0, 0);
        check(pos_m == NSTATES - 4, "R2 reverse wrap model", pos_m, NSTATES - 4);
        // R9: idle clocks hold.
        for (int i = 0; i < 5; i++) cyc(0, 0, 0, 0, 0, 0);
        // R5: steps ignored while running with zero increment.
        rate_inc = '0;
        for (int i = 0; i < 6; i++) cyc(1, 0, 1, 0, 0, 0);

        // R4: half rate, forward then reverse.
        rate_inc = 24'h800000;
        for (int i = 0; i < 200; i++) cyc(1, 0, 0, 0, 0, 0);
        for (int i = 0; i < 300; i++) cyc(1, 1, 0, 0, 0, 0);

        // R6: slips in both directions and at the limits.
        cyc(0, 0, 0, 1, 100, 0);
        cyc(0, 0, 0, 1, -128, 0);
        cyc(0, 0, 0, 1, 127, 0);
        cyc(0, 1, 1, 1, -3, 0);

        // R7: request simulate away from zero, then slip onto zero.
        cyc(0, 0, 0, 1, 17 - pos_m % 100, 0);
        while (pos_m != 17) cyc(0, (pos_m > 17), 1, 0, 0, 0);
        for (int i = 0; i < 4; i++) cyc(0, 0, 0, 0, 0, 1);
        check(mode_sim == 1'b0, "R7 held off boundary", int'(mode_sim), 0);
        cyc(0, 0, 0, 1, -17, 1);
        check(mode_sim == 1'b1, "R7 switch at zero", int'(mode_sim), 1);
        // R7: return to run after a full revolution at near-full rate.
        rate_inc = 24'hFFFFFF;
        for (int i = 0; i < 6000; i++) cyc(1, 0, 0, 0, 0, 0);
        check(mode_sim == 1'b0, "R7 switch back at revolution", int'(mode_sim), 0);

        // R4: 3600 RPM increment in simulate mode.
        rate_inc = 24'd115965;
        for (int i = 0; i < 4000; i++) cyc(1, 0, 0, 0, 0, 1);

        // Mixed random stimulus across all controls.
        for (int i = 0; i < 30000; i++) begin
            int  sel;
            bit  ss_r;
            sel = int'($urandom_range(0, 99));
            enc_a_in = 1'($urandom);
            enc_b_in = 1'($urandom);
            enc_z_in = 1'($urandom);
            if (sel < 2) rate_inc = 24'($urandom);
            ss_r = (i / 3000) % 2 == 1;
            cyc(sel >= 40, ((i / 500) % 3) == 2, sel < 60 && sel >= 20,
                sel == 7 || sel == 77, int'($urandom_range(0, 255)), ss_r);
        end

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

endmodule